// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers seven interrupt causes from the surrounding peripheral logic into a pending-flag register, pairs each flag with a mask bit in an enable register, and drives one active-low interrupt request. A host reaches both registers through a small register bus (read strobe, write strobe, 4-bit offset and 8-bit write data). The same bus lets the block see accesses to neighbouring registers whose read or write must also retire a pending flag as a side effect.

The pending register clears flags when a 1 is written. Its read value carries a computed summary in bit 7. The enable register uses bit 7 of the written byte to choose whether the other ones set or clear mask bits. Each cause arrives as a one-cycle set pulse. The port-side handshake clears depend on two mode levels that say whether a port's secondary control line runs as an independent interrupt input.

Top module: `intr_collect`

## Requirements
- R1: While `rst` is high at a clock edge, every flag and every enable bit goes to 0. After reset, `pend_rd` reads 0x00, `arm_rd` reads 0x80 and `irq_n` is 1.
- R2: A 1 on `set_pulse[i]` sets flag i, seen on `pend_rd[i]` after the next clock edge. The bit map is: 0 port A secondary line edge, 1 port A primary line edge, 2 eight shifts done, 3 port B secondary line edge, 4 port B primary line edge, 5 timer 2 expiry, 6 timer 1 expiry.
- R3: `pend_rd[7]` is 1 exactly when some i in 0..6 has both flag i and enable i set, and `irq_n` is the inverse of `pend_rd[7]`.
- R4: A write to offset 0xD clears each flag whose data bit (6:0) is 1 and leaves the other flags alone. Data bit 7 has no effect.
- R5: A write to offset 0xE with data bit 7 = 1 sets each enable bit whose data bit (6:0) is 1, and leaves the others unchanged.
- R6: A write to offset 0xE with data bit 7 = 0 clears each enable bit whose data bit (6:0) is 1, and leaves the others unchanged.
- R7: `arm_rd[7]` always reads 1, and `arm_rd[6:0]` shows the enable bits.
- R8: A read or write at offset 0x1 clears flag 1. It also clears flag 0 unless `a_sec_indep` is 1.
- R9: A read or write at offset 0x0 clears flag 4. It also clears flag 3 unless `b_sec_indep` is 1.
- R10: A read or write at offset 0xF leaves flags 0 and 1 unchanged.
- R11: A read or write at offset 0xA clears flag 2.
- R12: A read at 0x4 or a write at 0x5 clears flag 6. A read at 0x8 or a write at 0x9 clears flag 5. A write at 0x4, a read at 0x5, a write at 0x8 and a read at 0x9 clear neither flag.
- R13: When a set pulse and any clear of the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse | input | 7 | Per-cause set pulses, bit map as in R2 |
| a_sec_indep | input | 1 | Port A secondary line is an independent interrupt input |
| b_sec_indep | input | 1 | Port B secondary line is an independent interrupt input |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| pend_rd | output | 8 | Pending register read value, summary in bit 7 |
| arm_rd | output | 8 | Enable register read value, bit 7 fixed at 1 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that a register access asserts at most one of `bus_rd` and `bus_wr` in a cycle. They also assume that the mode levels `a_sec_indep` and `b_sec_indep` do not change during an access cycle. The directed tasks change the mode levels only while the bus is idle, and each access helper raises exactly one strobe for exactly one cycle. Set pulses come either alone or in a deliberate overlap with a clearing access, so the set-wins case is reached on purpose and never by accident.

// File: rtl/intr_collect_pkg.sv
package intr_collect_pkg;

    localparam int SRC_N  = 7;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    typedef logic [SRC_N-1:0]  src_vec_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // Bit position of each interrupt cause (decoded by software).
    typedef enum logic [2:0] {
        SRC_A_SEC = 3'd0,
        SRC_A_PRI = 3'd1,
        SRC_SHIFT = 3'd2,
        SRC_B_SEC = 3'd3,
        SRC_B_PRI = 3'd4,
        SRC_TMR2  = 3'd5,
        SRC_TMR1  = 3'd6
    } src_e;

    // Register offsets whose access has an effect here.
    localparam addr_t ADR_PORT_B    = 4'h0;
    localparam addr_t ADR_PORT_A    = 4'h1;
    localparam addr_t ADR_T1_LO     = 4'h4;
    localparam addr_t ADR_T1_HI     = 4'h5;
    localparam addr_t ADR_T2_LO     = 4'h8;
    localparam addr_t ADR_T2_HI     = 4'h9;
    localparam addr_t ADR_SHIFT     = 4'hA;
    localparam addr_t ADR_PEND      = 4'hD;
    localparam addr_t ADR_ARM       = 4'hE;
    localparam addr_t ADR_PORT_A_NQ = 4'hF;

    typedef struct packed {
        logic  rd;
        logic  wr;
        addr_t addr;
        data_t wdata;
    } bus_req_t;

    typedef struct packed {
        src_vec_t clr;
        logic     arm_we;
        logic     arm_set;
        src_vec_t arm_bits;
    } reg_upd_t;

    function automatic src_vec_t src_bit(input src_e s);
        src_vec_t v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    function automatic logic hits(input bus_req_t b, input addr_t a);
        return (b.rd || b.wr) && (b.addr == a);
    endfunction

endpackage

// File: rtl/intr_access_decode.sv
module intr_access_decode
    import intr_collect_pkg::*;
(
    input  bus_req_t bus,
    input  logic     a_sec_indep,
    input  logic     b_sec_indep,
    output reg_upd_t upd
);
    src_vec_t clr_side;
    src_vec_t clr_host;

    always_comb begin
        clr_side = '0;
        if (hits(bus, ADR_PORT_A)) begin
            clr_side |= src_bit(SRC_A_PRI);
            if (!a_sec_indep) clr_side |= src_bit(SRC_A_SEC);
        end
        if (hits(bus, ADR_PORT_B)) begin
            clr_side |= src_bit(SRC_B_PRI);
            if (!b_sec_indep) clr_side |= src_bit(SRC_B_SEC);
        end
        if (hits(bus, ADR_SHIFT))
            clr_side |= src_bit(SRC_SHIFT);
        if ((bus.rd && bus.addr == ADR_T1_LO) || (bus.wr && bus.addr == ADR_T1_HI))
            clr_side |= src_bit(SRC_TMR1);
        if ((bus.rd && bus.addr == ADR_T2_LO) || (bus.wr && bus.addr == ADR_T2_HI))
            clr_side |= src_bit(SRC_TMR2);
    end

    always_comb begin
        clr_host = '0;
        if (bus.wr && bus.addr == ADR_PEND)
            clr_host = bus.wdata[SRC_N-1:0];
    end

    always_comb begin
        upd.clr      = clr_side | clr_host;
        upd.arm_we   = bus.wr && (bus.addr == ADR_ARM);
        upd.arm_set  = bus.wdata[DATA_W-1];
        upd.arm_bits = bus.wdata[SRC_N-1:0];
    end
endmodule

// File: rtl/intr_flag_bank.sv
module intr_flag_bank
    import intr_collect_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_in,
    input  logic [N-1:0] clr_in,
    output logic [N-1:0] flags
);
    // One cell per cause; a set in the same cycle beats any clear.
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (set_in[i])
                flags[i] <= 1'b1;
            else if (clr_in[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/intr_arm_reg.sv
module intr_arm_reg
    import intr_collect_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic         set_mode,
    input  logic [N-1:0] bits,
    output logic [N-1:0] arm
);
    for (genvar i = 0; i < N; i++) begin : g_arm
        always_ff @(posedge clk) begin
            if (rst)
                arm[i] <= 1'b0;
            else if (we && bits[i])
                arm[i] <= set_mode;
        end
    end
endmodule

// File: rtl/intr_summary.sv
module intr_summary
    import intr_collect_pkg::*;
#(
    parameter int N = SRC_N,
    parameter int W = DATA_W
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] arm,
    output logic [W-1:0] pend_rd,
    output logic [W-1:0] arm_rd,
    output logic         irq_n
);
    localparam int PAD = W - N - 1;

    logic active;

    always_comb begin
        active = |(flags & arm);
        irq_n  = ~active;
    end

    if (PAD > 0) begin : g_pad
        assign pend_rd = {active, {PAD{1'b0}}, flags};
        assign arm_rd  = {1'b1,   {PAD{1'b0}}, arm};
    end else begin : g_nopad
        assign pend_rd = {active, flags};
        assign arm_rd  = {1'b1,   arm};
    end
endmodule

// File: rtl/intr_collect.sv
module intr_collect
    import intr_collect_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [6:0] set_pulse,
    input  logic       a_sec_indep,
    input  logic       b_sec_indep,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] pend_rd,
    output logic [7:0] arm_rd,
    output logic       irq_n
);
    bus_req_t bus;
    reg_upd_t upd;
    src_vec_t flags;
    src_vec_t arm;

    always_comb begin
        bus.rd    = bus_rd;
        bus.wr    = bus_wr;
        bus.addr  = bus_addr;
        bus.wdata = bus_wdata;
    end

    intr_access_decode u_decode (
        .bus         (bus),
        .a_sec_indep (a_sec_indep),
        .b_sec_indep (b_sec_indep),
        .upd         (upd)
    );

    intr_flag_bank #(.N(SRC_N)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_in (set_pulse),
        .clr_in (upd.clr),
        .flags  (flags)
    );

    intr_arm_reg #(.N(SRC_N)) u_arm (
        .clk      (clk),
        .rst      (rst),
        .we       (upd.arm_we),
        .set_mode (upd.arm_set),
        .bits     (upd.arm_bits),
        .arm      (arm)
    );

    intr_summary #(.N(SRC_N), .W(DATA_W)) u_sum (
        .flags   (flags),
        .arm     (arm),
        .pend_rd (pend_rd),
        .arm_rd  (arm_rd),
        .irq_n   (irq_n)
    );
endmodule

// File: rtl/intr_collect_chk.sv
module intr_collect_chk
    import intr_collect_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [6:0] set_pulse,
    input logic       a_sec_indep,
    input logic       b_sec_indep,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] pend_rd,
    input logic [7:0] arm_rd,
    input logic       irq_n
);
    logic acc;
    assign acc = bus_rd || bus_wr;

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        (set_pulse != '0) |=> ((pend_rd[6:0] & $past(set_pulse)) == $past(set_pulse)));

    assert_summary_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_rd[7] == |(pend_rd[6:0] & arm_rd[6:0])) && (irq_n == !pend_rd[7]));

    assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADR_PEND)
        |=> ((pend_rd[6:0] & $past(bus_wdata[6:0] & ~set_pulse)) == '0));

    assert_arm_set_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADR_ARM && bus_wdata[7])
        |=> ((arm_rd[6:0] & $past(bus_wdata[6:0])) == $past(bus_wdata[6:0])));

    assert_arm_clr_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADR_ARM && !bus_wdata[7])
        |=> ((arm_rd[6:0] & $past(bus_wdata[6:0])) == '0));

    assert_arm_msb_R7: assert property (@(posedge clk) disable iff (rst) arm_rd[7]);

    assert_port_a_R8: assert property (@(posedge clk) disable iff (rst)
        (acc && bus_addr == ADR_PORT_A && !set_pulse[1]) |=> !pend_rd[1]);

    assert_port_b_R9: assert property (@(posedge clk) disable iff (rst)
        (acc && bus_addr == ADR_PORT_B && !set_pulse[4]) |=> !pend_rd[4]);

    assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (acc && bus_addr == ADR_PORT_A_NQ)
        |=> ((pend_rd[1:0] & $past(pend_rd[1:0])) == $past(pend_rd[1:0])));

    assert_shift_R11: assert property (@(posedge clk) disable iff (rst)
        (acc && bus_addr == ADR_SHIFT && !set_pulse[2]) |=> !pend_rd[2]);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (set_pulse == '0 && !acc) |=> $stable(pend_rd[6:0]));

    assert_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));
endmodule

bind intr_collect intr_collect_chk u_chk (.*);

// File: tb/intr_collect_bench.sv
module intr_collect_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] set_pulse = '0;
    logic       a_sec_indep = 1'b0;
    logic       b_sec_indep = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] pend_rd;
    logic [7:0] arm_rd;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_collect u_intr_collect (
        .clk(clk), .rst(rst), .set_pulse(set_pulse),
        .a_sec_indep(a_sec_indep), .b_sec_indep(b_sec_indep),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pend_rd(pend_rd), .arm_rd(arm_rd),
        .irq_n(irq_n)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [6:0] m);
        set_pulse = m;
        tick();
        set_pulse = '0;
    endtask

    task automatic rd(input logic [3:0] a);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic clear_all();
        wr(4'hD, 8'h7F);
    endtask

    task automatic t_reset();
        check("R1 flags", pend_rd, 8'h00);
        check("R1 enables", arm_rd, 8'h80);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_set_each();
        logic [7:0] exp = 8'h00;
        for (int i = 0; i < 7; i++) begin
            pulse(7'(1 << i));
            exp[i] = 1'b1;
            check("R2 set", pend_rd, exp);
        end
        check("R3 masked", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_flag_w1c();
        wr(4'hD, 8'h85);
        check("R4 w1c", pend_rd, 8'h7A);
        wr(4'hD, 8'h00);
        check("R4 zeros", pend_rd, 8'h7A);
    endtask

    task automatic t_arm();
        wr(4'hE, 8'h83);
        check("R5 set", arm_rd, 8'h83);
        wr(4'hE, 8'h8C);
        check("R5 keep", arm_rd, 8'h8F);
        wr(4'hE, 8'h05);
        check("R6 clear", arm_rd, 8'h8A);
        wr(4'hE, 8'h00);
        check("R6 zeros", arm_rd, 8'h8A);
        check("R7 msb", {7'd0, arm_rd[7]}, 8'h01);
    endtask

    task automatic t_summary();
        check("R3 active", pend_rd, 8'hFA);
        check("R3 irq low", {7'd0, irq_n}, 8'h00);
        wr(4'hD, 8'h0A);
        check("R3 inactive", pend_rd, 8'h70);
        check("R3 irq high", {7'd0, irq_n}, 8'h01);
        wr(4'hE, 8'h7F);
        check("R6 all clear", arm_rd, 8'h80);
    endtask

    task automatic t_port_a();
        clear_all();
        pulse(7'h03);
        rd(4'h1);
        check("R8 read clears", pend_rd, 8'h00);
        a_sec_indep = 1'b1;
        pulse(7'h03);
        wr(4'h1, 8'hFF);
        check("R8 indep keeps", pend_rd, 8'h01);
        a_sec_indep = 1'b0;
        wr(4'h1, 8'h00);
        check("R8 write clears", pend_rd, 8'h00);
    endtask

    task automatic t_port_b();
        clear_all();
        pulse(7'h18);
        wr(4'h0, 8'h55);
        check("R9 write clears", pend_rd, 8'h00);
        b_sec_indep = 1'b1;
        pulse(7'h18);
        rd(4'h0);
        check("R9 indep keeps", pend_rd, 8'h08);
        b_sec_indep = 1'b0;
    endtask

    task automatic t_quiet();
        clear_all();
        pulse(7'h03);
        rd(4'hF);
        check("R10 read", pend_rd, 8'h03);
        wr(4'hF, 8'hFF);
        check("R10 write", pend_rd, 8'h03);
    endtask

    task automatic t_shift();
        clear_all();
        pulse(7'h04);
        rd(4'hA);
        check("R11 read", pend_rd, 8'h00);
        pulse(7'h04);
        wr(4'hA, 8'h3C);
        check("R11 write", pend_rd, 8'h00);
    endtask

    task automatic t_timers();
        clear_all();
        pulse(7'h60);
        wr(4'h4, 8'h11);
        rd(4'h5);
        wr(4'h8, 8'h22);
        rd(4'h9);
        check("R12 no clear", pend_rd, 8'h60);
        rd(4'h4);
        check("R12 t1 read lo", pend_rd, 8'h20);
        wr(4'h9, 8'h01);
        check("R12 t2 write hi", pend_rd, 8'h00);
        pulse(7'h60);
        wr(4'h5, 8'h01);
        rd(4'h8);
        check("R12 t1 hi t2 lo", pend_rd, 8'h00);
    endtask

    task automatic t_race();
        clear_all();
        set_pulse = 7'h40; bus_rd = 1'b1; bus_addr = 4'h4;
        tick();
        set_pulse = '0; bus_rd = 1'b0;
        check("R13 side clear", pend_rd, 8'h40);
        set_pulse = 7'h01; bus_wr = 1'b1; bus_addr = 4'hD; bus_wdata = 8'h41;
        tick();
        set_pulse = '0; bus_wr = 1'b0;
        check("R13 host clear", pend_rd, 8'h01);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        t_reset();
        t_set_each();
        t_flag_w1c();
        t_arm();
        t_summary();
        t_port_a();
        t_port_b();
        t_quiet();
        t_shift();
        t_timers();
        t_race();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule